// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by walking a two-level translation structure held in memory. A base register points at the page directory. The upper index field of the virtual address picks one directory entry. That entry's frame number points at a page table. The middle index field then picks one page table entry, and that entry's frame number, joined with the untouched page offset, gives the physical address.

A client raises a one-cycle request carrying the virtual address and a write flag. The walker then issues up to two dependent reads on a single memory read port, waiting for each read-valid. It returns a one-cycle completion pulse carrying either the physical address or a fault code. A directory entry whose valid bit is clear marks a region with no present pages, so the walk faults after one read. A separate register-write port loads the directory base.

Pages are 512 bytes and entries are 4 bytes, so each directory and each table holds 128 entries.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy_o, done_o and mem_rd_o are low.
- R2: The virtual address splits into an offset in bits [8:0], a table index in bits [15:9] and a directory index in bits [22:16]. All-ones indices and offset translate correctly.
- R3: The first read of a walk has address base + directory index * 4. Every read strobe mem_rd_o lasts exactly one cycle and occurs only while busy_o is high.
- R4: A second read is issued only after the first read-valid arrives. It has address (directory entry bits [31:9]) * 512 + table index * 4.
- R5: A directory entry with bit 0 (valid) clear ends the walk with fault code 2'b01, after exactly one read, and paddr_o is zero.
- R6: A page table entry with bit 0 (valid) clear ends the walk with fault code 2'b10, and paddr_o is zero.
- R7: A valid page table entry with bit 1 (protect) set gives fault code 2'b11 for a write request. The same entry translates normally for a read, and an entry with bit 1 clear accepts writes.
- R8: A successful walk gives fault code 2'b00 and paddr_o = {page table entry bits [31:9], virtual offset}.
- R9: done_o is high for exactly one cycle. With a read-valid L cycles after each read strobe, done_o comes 2L+3 cycles after the accepting edge, or L+2 cycles after it on a directory fault.
- R10: A request is accepted only while busy_o is low. A request raised during a walk does not change that walk's reads or its result, and it does not start another walk.
- R11: A write on the base port changes the directory read address of the walks that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_we_i | input | 1 | Load the directory base register |
| base_i | input | 32 | New directory base (physical byte address) |
| req_valid_i | input | 1 | Translation request, taken when busy_o is low |
| req_vaddr_i | input | 23 | Virtual address to translate |
| req_write_i | input | 1 | Request is a write access |
| busy_o | output | 1 | Walk in progress |
| mem_rd_o | output | 1 | One-cycle memory read strobe |
| mem_addr_o | output | 32 | Memory read address, valid with mem_rd_o |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 32 | Memory read data (a directory or table entry) |
| done_o | output | 1 | One-cycle walk completion |
| paddr_o | output | 32 | Physical address, valid with done_o |
| fault_o | output | 2 | 00 ok, 01 directory not present, 10 page not present, 11 protection |

## Verification
The bench models memory with a programmable read latency L and runs every vector at L = 1 and at L = 3. It counts clock edges from the accepting edge to the cycle where done_o is seen, and expects 2L+3 cycles for a full walk and L+2 for a directory fault. All outputs are sampled on the falling edge, in the middle of the cycle, after the registers that feed them have settled. The memory model logs each strobed address mid-cycle, and the bench compares the count and addresses of the reads with values computed from the base, the indices and the stored directory entry.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_PDE, ST_WAIT_PDE, ST_READ_PTE, ST_WAIT_PTE, ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_DIR  = 2'b01,
    FLT_PAGE = 2'b10,
    FLT_PROT = 2'b11
  } fault_e;

  localparam int unsigned VALID_BIT   = 0;
  localparam int unsigned PROTECT_BIT = 1;
endpackage

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec #(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 9,
  localparam int unsigned FRAME_W = PA_W - OFF_W
) (
  input  logic [FRAME_W-1:0] frame_bits_i,
  input  logic               valid_bit_i,
  input  logic               protect_bit_i,
  output logic               valid_o,
  output logic               protect_o,
  output logic [FRAME_W-1:0] frame_o
);
  assign valid_o   = valid_bit_i;
  assign protect_o = valid_bit_i & protect_bit_i;
  assign frame_o   = frame_bits_i;
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 9,
  localparam int unsigned IDX_W   = OFF_W - 2,
  localparam int unsigned FRAME_W = PA_W - OFF_W
) (
  input  logic [PA_W-1:0]    base_i,
  input  logic [IDX_W-1:0]   dir_idx_i,
  input  logic [IDX_W-1:0]   tbl_idx_i,
  input  logic [FRAME_W-1:0] pt_frame_i,
  input  logic               sel_pte_i,
  output logic [PA_W-1:0]    addr_o
);
  logic [PA_W-1:0] pde_addr, pte_addr;

  // entries are 4 bytes: index scaled by 4
  assign pde_addr = base_i + {{(PA_W-IDX_W-2){1'b0}}, dir_idx_i, 2'b00};
  assign pte_addr = {pt_frame_i, tbl_idx_i, 2'b00};
  assign addr_o   = sel_pte_i ? pte_addr : pde_addr;
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        mem_rvalid_i,
  input  logic        pde_valid_i,
  output walk_state_e state_o,
  output logic        accept_o
);
  walk_state_e state_q, state_d;

  assign accept_o = (state_q == ST_IDLE) && req_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid_i) state_d = ST_READ_PDE;
      ST_READ_PDE: state_d = ST_WAIT_PDE;
      ST_WAIT_PDE: if (mem_rvalid_i) state_d = pde_valid_i ? ST_READ_PTE : ST_DONE;
      ST_READ_PTE: state_d = ST_WAIT_PTE;
      ST_WAIT_PTE: if (mem_rvalid_i) state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 9,
  localparam int unsigned IDX_W   = OFF_W - 2,
  localparam int unsigned VA_W    = 2 * IDX_W + OFF_W,
  localparam int unsigned FRAME_W = PA_W - OFF_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            base_we_i,
  input  logic [PA_W-1:0] base_i,
  input  logic            req_valid_i,
  input  logic [VA_W-1:0] req_vaddr_i,
  input  logic            req_write_i,
  output logic            busy_o,
  output logic            mem_rd_o,
  output logic [PA_W-1:0] mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [PA_W-1:0] mem_rdata_i,
  output logic            done_o,
  output logic [PA_W-1:0] paddr_o,
  output logic [1:0]      fault_o
);
  walk_state_e        state;
  logic               accept;
  logic [PA_W-1:0]    base_q;
  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic [FRAME_W-1:0] pt_frame_q;
  logic [PA_W-1:0]    paddr_q;
  fault_e             fault_q;
  logic               ent_valid, ent_prot;
  logic [FRAME_W-1:0] ent_frame;
  logic               pde_rsp, pte_rsp;

  ptw_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .mem_rvalid_i (mem_rvalid_i),
    .pde_valid_i  (ent_valid),
    .state_o      (state),
    .accept_o     (accept)
  );

  ptw_entry_dec #(.PA_W(PA_W), .OFF_W(OFF_W)) u_dec (
    .frame_bits_i  (mem_rdata_i[PA_W-1:OFF_W]),
    .valid_bit_i   (mem_rdata_i[VALID_BIT]),
    .protect_bit_i (mem_rdata_i[PROTECT_BIT]),
    .valid_o       (ent_valid),
    .protect_o     (ent_prot),
    .frame_o       (ent_frame)
  );

  ptw_addr_gen #(.PA_W(PA_W), .OFF_W(OFF_W)) u_agen (
    .base_i     (base_q),
    .dir_idx_i  (va_q[VA_W-1 -: IDX_W]),
    .tbl_idx_i  (va_q[OFF_W +: IDX_W]),
    .pt_frame_i (pt_frame_q),
    .sel_pte_i  (state == ST_READ_PTE),
    .addr_o     (mem_addr_o)
  );

  assign pde_rsp = (state == ST_WAIT_PDE) && mem_rvalid_i;
  assign pte_rsp = (state == ST_WAIT_PTE) && mem_rvalid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else if (base_we_i) base_q <= base_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q       <= '0;
      wr_q       <= 1'b0;
      pt_frame_q <= '0;
      paddr_q    <= '0;
      fault_q    <= FLT_NONE;
    end else begin
      if (accept) begin
        va_q <= req_vaddr_i;
        wr_q <= req_write_i;
      end
      if (pde_rsp) begin
        pt_frame_q <= ent_frame;
        if (!ent_valid) begin
          fault_q <= FLT_DIR;
          paddr_q <= '0;
        end
      end
      if (pte_rsp) begin
        if (!ent_valid) begin
          fault_q <= FLT_PAGE;
          paddr_q <= '0;
        end else if (wr_q && ent_prot) begin
          fault_q <= FLT_PROT;
          paddr_q <= '0;
        end else begin
          fault_q <= FLT_NONE;
          paddr_q <= {ent_frame, va_q[OFF_W-1:0]};
        end
      end
    end
  end

  assign busy_o   = (state != ST_IDLE);
  assign mem_rd_o = (state == ST_READ_PDE) || (state == ST_READ_PTE);
  assign done_o   = (state == ST_DONE);
  assign paddr_o  = paddr_q;
  assign fault_o  = fault_q;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [OFF_W-1:0] req_off_i,
  input logic             busy_o,
  input logic             mem_rd_o,
  input logic             done_o,
  input logic [PA_W-1:0]  paddr_o,
  input logic [1:0]       fault_o
);
  logic [1:0]       rd_cnt_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt_q <= '0;
      off_q    <= '0;
    end else if (req_valid_i && !busy_o) begin
      rd_cnt_q <= '0;
      off_q    <= req_off_i;
    end else if (mem_rd_o) begin
      rd_cnt_q <= rd_cnt_q + 2'd1;
    end
  end

  p_rd_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  p_rd_in_walk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_rd_o);

  p_dir_fault_one_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == 2'b01) |-> (rd_cnt_q == 2'd1 && paddr_o == '0));

  p_two_reads_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o != 2'b01) |-> rd_cnt_q == 2'd2);

  p_offset_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == 2'b00) |-> paddr_o[OFF_W-1:0] == off_q);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_start_on_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i));
endmodule

bind pt_walker ptw_checker #(.PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_off_i   (req_vaddr_i[OFF_W-1:0]),
  .busy_o      (busy_o),
  .mem_rd_o    (mem_rd_o),
  .done_o      (done_o),
  .paddr_o     (paddr_o),
  .fault_o     (fault_o)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  localparam int PA_W = 32;
  localparam int VA_W = 23;

  typedef struct packed {
    logic [22:0] va;
    logic        wr;
    logic [1:0]  flt;
    logic [31:0] pa;
    logic [1:0]  nrd;
  } vec_t;

  // memory image: base 0x1000, dir 3 -> table at 0x4000, dir 127 -> table at 0xFE00
  localparam vec_t VECS [7] = '{
    '{23'h030BAB, 1'b0, 2'b00, 32'h0002ABAB, 2'd2},  // R8 plain read
    '{23'h030A00, 1'b1, 2'b00, 32'h0002AA00, 2'd2},  // R7 write, unprotected
    '{23'h030C10, 1'b0, 2'b00, 32'h0000EE10, 2'd2},  // R7 read of protected page
    '{23'h030C10, 1'b1, 2'b11, 32'h00000000, 2'd2},  // R7 write of protected page
    '{23'h030E00, 1'b0, 2'b10, 32'h00000000, 2'd2},  // R6 page not present
    '{23'h0901FF, 1'b0, 2'b01, 32'h00000000, 2'd1},  // R5 directory not present
    '{23'h7FFFFF, 1'b0, 2'b00, 32'hFFFFFFFF, 2'd2}   // R2 all-ones fields
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_we = 1'b0;
  logic [PA_W-1:0] base = '0;
  logic req_valid = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic req_write = 1'b0;
  logic busy, mem_rd, done;
  logic [PA_W-1:0] mem_addr, paddr;
  logic mem_rvalid = 1'b0;
  logic [PA_W-1:0] mem_rdata = '0;
  logic [1:0] fault;

  int checks = 0;
  int fails = 0;
  int lat = 1;
  int rd_count = 0;
  int pend_cnt = 0;
  logic [31:0] pend_addr = '0;
  logic [31:0] rd_log [4];
  logic [31:0] cur_base = 32'h1000;
  logic [31:0] mem [logic [31:0]];

  always #2 clk = ~clk;

  pt_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .base_we_i(base_we), .base_i(base),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_write_i(req_write),
    .busy_o(busy), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .paddr_o(paddr), .fault_o(fault)
  );

  function automatic logic [31:0] mem_rd_word(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory model: read-valid lat cycles after the strobe cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 1'b0;
      pend_cnt = 0;
    end else begin
      mem_rvalid = 1'b0;
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata = mem_rd_word(pend_addr);
        end
      end
      if (mem_rd) begin
        pend_addr = mem_addr;
        pend_cnt = lat;
        if (rd_count < 4) rd_log[rd_count] = mem_addr;
        rd_count++;
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_base(logic [31:0] b);
    @(negedge clk);
    base_we = 1'b1;
    base = b;
    @(negedge clk);
    base_we = 1'b0;
    cur_base = b;
  endtask

  // start a walk; when hold_req>0 keep req_valid high that many extra cycles with another address
  task automatic walk(logic [22:0] va, logic wr, int hold_req, output int cyc);
    @(negedge clk);
    rd_count = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    req_write = wr;
    @(posedge clk);
    @(negedge clk);
    if (hold_req > 0) req_vaddr = 23'h0901FF;
    else req_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 200) begin
      if (cyc >= hold_req) req_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    if (cyc >= 200) begin
      fails++;
      $display("FAIL R9 watchdog: actual no done, expected done");
    end
  endtask

  task automatic run_vec(vec_t v, int l, int hold_req, string tag);
    int cyc;
    logic [31:0] pde_a, pde;
    lat = l;
    walk(v.va, v.wr, hold_req, cyc);
    pde_a = cur_base + {23'h0, v.va[22:16], 2'b00};
    chk(tag, "fault", {30'h0, fault}, {30'h0, v.flt});
    chk(tag, "paddr", paddr, v.pa);
    chk(tag, "reads", rd_count, {30'h0, v.nrd});
    chk("R3", "pde address", rd_log[0], pde_a);
    if (v.nrd == 2'd2) begin
      pde = mem_rd_word(pde_a);
      chk("R4", "pte address", rd_log[1], {pde[31:9], v.va[15:9], 2'b00});
    end
    chk("R9", "latency", cyc, (v.flt == 2'b01) ? l + 2 : 2 * l + 3);
    @(negedge clk);
    chk("R9", "done one cycle", {31'h0, done}, 32'h0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout, expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    mem[32'h0000100C] = (32'h20 << 9) | 32'h1;
    mem[32'h00004014] = (32'h155 << 9) | 32'h1;
    mem[32'h00004018] = (32'h77 << 9) | 32'h3;
    mem[32'h0000401C] = 32'h0;
    mem[32'h00001024] = 32'h0;
    mem[32'h000011FC] = (32'h7F << 9) | 32'h1;
    mem[32'h0000FFFC] = 32'hFFFFFE01;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", {31'h0, busy}, 32'h0);
    chk("R1", "done", {31'h0, done}, 32'h0);
    chk("R1", "mem_rd", {31'h0, mem_rd}, 32'h0);
    rst_n = 1'b1;
    load_base(32'h1000);

    for (int l = 1; l <= 3; l += 2)
      for (int i = 0; i < 7; i++)
        run_vec(VECS[i], l, 0, (i == 6) ? "R2" : (i == 5) ? "R5" : (i == 4) ? "R6" : (i == 0) ? "R8" : "R7");

    // R10 request held during a walk is ignored
    run_vec(VECS[0], 3, 5, "R10");
    @(negedge clk);
    chk("R10", "no extra walk", {31'h0, busy}, 32'h0);

    // R11 new base: directory 3 now at 0x200C, left empty -> directory fault
    mem[32'h0000200C] = 32'h0;
    load_base(32'h2000);
    run_vec('{23'h030BAB, 1'b0, 2'b01, 32'h0, 2'd1}, 1, 0, "R11");
    load_base(32'h1000);
    run_vec(VECS[0], 1, 0, "R11");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule